// File: doc/BRIEF.md
# Column-Serial AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It is built for small area. Each clock it works on one 32-bit column of the state, through four byte-substitution units and one column mixer. A round therefore takes four clocks, and a whole block takes forty.

Round-key words are produced inside the block, one word per clock, from the previous round's key. No expanded key is stored. Only one block is in flight at a time, so a wrapper can feed each ciphertext back into the next input to build a chaining mode.

Usage:
- The user presents the plaintext and the key with a one-cycle start pulse.
- The user waits for the done pulse.
- The user reads the ciphertext, which stays on its port until the next accepted start.

Top module: `aes_enc_colserial`

## Requirements
- R1: While the synchronous active-low reset is low, and right after it, busy and done are 0 and the ciphertext port reads all zeros.
- R2: Byte order: bit [127:120] of each 128-bit port is state byte 0 (column 0, row 0), the next byte is row 1 of column 0, and so on, column by column. With key 000102…0F and plaintext 00112233…FF, the result is 69C4E0D86A7B0430D8CDB78070B4C55A.
- R3: A start seen while busy is low is accepted at that clock edge. From the next cycle busy stays high for exactly 40 cycles. The done pulse appears in the 40th cycle after the accepting edge, in the same cycle that busy returns low.
- R4: Done is high for exactly one cycle. The ciphertext stays unchanged from the done cycle until the next accepted start, whatever the data inputs do.
- R5: A start pulse while busy is high is ignored. The running block finishes with its own data and its own latency, and no extra block follows it.
- R6: A start given in the done cycle is accepted, so blocks can run back to back with no idle cycle between them.
- R7: For any key and plaintext, the output equals AES-128 encryption. This means whitening with the key, then ten rounds, with column mixing left out of the tenth round and round keys expanded by the standard schedule (round constant starting at 01 and doubled in GF(2^8)). The all-zero and all-one cases are included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to encrypt the presented block |
| pt_i | input | 128 | Plaintext, sampled with an accepted start |
| key_i | input | 128 | Cipher key, sampled with an accepted start |
| busy_o | output | 1 | High while a block is being processed |
| done_o | output | 1 | One-cycle pulse when the ciphertext is ready |
| ct_o | output | 128 | Ciphertext, held until the next accepted start |

## Verification
The hardest situation to reach from the ports is a start request that collides with a running block, especially one in the last busy cycle, where busy is about to fall. The stimulus injects stray starts with different data at every cycle offset from 0 to 39 across a series of runs. It then also issues a start exactly in the done cycle. In both cases the expected ciphertext and the expected latency come from a reference cipher written inside the bench.

// File: rtl/aes_col_pkg.sv
// Package: shared byte/word types and GF(2^8) helpers for the column-serial
// AES-128 core. Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aes_col_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // Multiply by x in GF(2^8)
    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General GF(2^8) product, shift-and-add
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // Substitution: inverse as a^254 (0 stays 0), then the affine map
    function automatic byte_t sub_byte(input byte_t a);
        byte_t sq;
        byte_t inv;
        byte_t res;
        sq  = a;
        inv = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        for (int i = 0; i < BYTE_W; i++) begin
            res[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8]
                   ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8];
        end
        return res ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_sbox.sv
// Module: one byte-substitution unit, purely combinational.
// Assumes no registers inside; the caller times the path.
module aes_sbox
    import aes_col_pkg::*;
(
    input  byte_t in_b,
    output byte_t out_b
);
    // Map one byte through the cipher's substitution
    always_comb out_b = sub_byte(in_b);
endmodule

// File: rtl/aes_col_unit.sv
// Module: one column of a round: four substitutions, optional column mixing,
// then round-key addition. The input bytes are already row-shifted.
// Assumes byte 0 (row 0) sits in bits [31:24].
module aes_col_unit
    import aes_col_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  word_t col_in,
    input  word_t rkey,
    input  logic  skip_mix,
    output word_t col_out
);
    byte_t sb [ROWS];
    byte_t mx [ROWS];

    genvar j;
    generate
        for (j = 0; j < ROWS; j++) begin : g_sub
            aes_sbox u_sb (
                .in_b (col_in[WORD_W-1-BYTE_W*j -: BYTE_W]),
                .out_b(sb[j])
            );
        end
    endgenerate

    // Column mixing: 2*a(j) ^ 3*a(j+1) ^ a(j+2) ^ a(j+3)
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            mx[r] = xtime(sb[r]) ^ xtime(sb[(r + 1) % ROWS]) ^ sb[(r + 1) % ROWS]
                  ^ sb[(r + 2) % ROWS] ^ sb[(r + 3) % ROWS];
        end
    end

    // Select mixed or plain bytes, then add the round key word
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            col_out[WORD_W-1-BYTE_W*r -: BYTE_W] =
                (skip_mix ? sb[r] : mx[r]) ^ rkey[WORD_W-1-BYTE_W*r -: BYTE_W];
        end
    end
endmodule

// File: rtl/aes_key_word.sv
// Module: one step of the word-serial key schedule. Produces round-key word c
// from word c of the previous round key and the word just before it (the new
// word c-1, or the old word 3 when c is 0). Has its own substitution units.
module aes_key_word
    import aes_col_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  word_t old_w,
    input  word_t prev_w,
    input  logic  first,
    input  byte_t rcon,
    output word_t new_w
);
    word_t rot;
    word_t subw;

    // Rotate the word left by one byte
    always_comb rot = {prev_w[WORD_W-BYTE_W-1:0], prev_w[WORD_W-1 -: BYTE_W]};

    genvar j;
    generate
        for (j = 0; j < ROWS; j++) begin : g_ksub
            aes_sbox u_ks (
                .in_b (rot[WORD_W-1-BYTE_W*j -: BYTE_W]),
                .out_b(subw[WORD_W-1-BYTE_W*j -: BYTE_W])
            );
        end
    endgenerate

    // First word takes substitution and round constant; the others a plain XOR
    always_comb begin
        if (first) new_w = old_w ^ subw ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};
        else       new_w = old_w ^ prev_w;
    end
endmodule

// File: rtl/aes_enc_colserial.sv
// Module: AES-128 encryption core with a 32-bit column datapath. One column
// per clock, four clocks per round, NR rounds; round keys made in the cycle of
// use from the previous round key held in place. Assumes one block at a time;
// start is ignored while busy. Synchronous active-low reset.
module aes_enc_colserial
    import aes_col_pkg::*;
#(
    parameter int NR   = 10,
    parameter int COLS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [127:0] pt_i,
    input  logic [127:0] key_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [127:0] ct_o
);
    localparam int RND_W = $clog2(NR + 1);
    localparam int COL_W = $clog2(COLS);
    localparam int ROWS  = 4;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    word_t             st  [COLS];
    word_t             kw  [COLS];
    word_t             nb  [COLS-1];
    logic [RND_W-1:0]  rnd;
    logic [COL_W-1:0]  col;
    byte_t             rcon;
    logic              busy;
    logic              done;

    word_t             shifted;
    word_t             prev_kw;
    word_t             rk_w;
    word_t             col_res;
    logic              last_rnd;

    // Gather the row-shifted input column: row j comes from column col+j
    always_comb begin
        for (int j = 0; j < ROWS; j++) begin
            logic [COL_W-1:0] src;
            src = col + COL_W'(j);
            shifted[WORD_W-1-BYTE_W*j -: BYTE_W] = st[src][WORD_W-1-BYTE_W*j -: BYTE_W];
        end
    end

    // Word preceding the one being expanded
    always_comb prev_kw = (col == '0) ? kw[COLS-1] : kw[col - 1'b1];

    always_comb last_rnd = (rnd == RND_W'(NR));

    aes_key_word #(.ROWS(ROWS)) u_kw (
        .old_w (kw[col]),
        .prev_w(prev_kw),
        .first (col == '0),
        .rcon  (rcon),
        .new_w (rk_w)
    );

    aes_col_unit #(.ROWS(ROWS)) u_col (
        .col_in  (shifted),
        .rkey    (rk_w),
        .skip_mix(last_rnd),
        .col_out (col_res)
    );

    // Sequencer, state, key words and next-state buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            rnd  <= RND_W'(1);
            col  <= '0;
            rcon <= 8'h01;
            for (int c = 0; c < COLS; c++) begin
                st[c] <= '0;
                kw[c] <= '0;
            end
            for (int c = 0; c < COLS-1; c++) nb[c] <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start_i) begin
                    for (int c = 0; c < COLS; c++) begin
                        st[c] <= pt_i[127-WORD_W*c -: WORD_W] ^ key_i[127-WORD_W*c -: WORD_W];
                        kw[c] <= key_i[127-WORD_W*c -: WORD_W];
                    end
                    busy <= 1'b1;
                    rnd  <= RND_W'(1);
                    col  <= '0;
                    rcon <= 8'h01;
                end
            end else begin
                kw[col] <= rk_w;
                col     <= col + 1'b1;
                if (col != LAST_COL) begin
                    nb[col] <= col_res;
                end else begin
                    for (int c = 0; c < COLS-1; c++) st[c] <= nb[c];
                    st[COLS-1] <= col_res;
                    rcon <= xtime(rcon);
                    if (last_rnd) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        rnd <= rnd + 1'b1;
                    end
                end
            end
        end
    end

    // Drive the ports from the state register
    always_comb begin
        for (int c = 0; c < COLS; c++) ct_o[127-WORD_W*c -: WORD_W] = st[c];
    end
    assign busy_o = busy;
    assign done_o = done;
endmodule

// File: rtl/aes_enc_colserial_chk.sv
// Checker: port-level timing properties of the column-serial core, bound to
// every instance. Counts busy cycles to check the block latency.
module aes_enc_colserial_chk #(
    parameter int NR   = 10,
    parameter int COLS = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [127:0] ct_o
);
    localparam int CNT_W = $clog2(NR * COLS + 2);
    logic [CNT_W-1:0] busy_cnt;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
        else             busy_cnt <= '0;
    end

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt == CNT_W'(NR * COLS)));

    assert_done_with_busy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ct_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(ct_o));

    assert_accept_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind aes_enc_colserial aes_enc_colserial_chk #(.NR(NR), .COLS(COLS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .ct_o   (ct_o)
);

// File: tb/sim_aes_enc_colserial.sv
module sim_aes_enc_colserial;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] pt_i = '0;
    logic [127:0] key_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] ct_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_t [256];
    logic [7:0] log_t [256];

    always #10 clk = ~clk;

    aes_enc_colserial u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pt_i(pt_i), .key_i(key_i),
        .busy_o(busy_o), .done_o(done_o), .ct_o(ct_o)
    );

    function automatic logic [7:0] xt(input logic [7:0] a);
        return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    function automatic logic [7:0] sref(input logic [7:0] a);
        logic [7:0] inv;
        inv = (a == 8'h00) ? 8'h00 : exp_t[(255 - int'(log_t[a])) % 255];
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
        logic [31:0] w [44];
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [31:0] tmp;
        logic [7:0]  rc;
        logic [127:0] res;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sref(tmp[23:16]), sref(tmp[15:8]), sref(tmp[7:0]), sref(tmp[31:24])}
                    ^ {rc, 24'h0};
                rc = xt(rc);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ key[127-8*i -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int c = 0; c < 4; c++)
                for (int j = 0; j < 4; j++) t[4*c+j] = sref(s[4*((c+j)%4)+j]);
            for (int c = 0; c < 4; c++) begin
                logic [7:0] a0, a1, a2, a3;
                a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
                if (r < 10) begin
                    t[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    t[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    t[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    t[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end
                for (int j = 0; j < 4; j++) s[4*c+j] = t[4*c+j] ^ w[4*r+c][31-8*j -: 8];
            end
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one block; inject_at >= 0 pulses a stray start that many cycles in.
    // chained=1 starts at the current negedge instead of waiting for the next.
    task automatic run_vec(input logic [127:0] pt, input logic [127:0] key,
                           input int inject_at, input bit chained);
        logic [127:0] exp;
        int lat;
        bit busy_ok;
        exp = ref_enc(pt, key);
        if (!chained) @(negedge clk);
        pt_i = pt; key_i = key; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; pt_i = ~pt; key_i = ~key;
        lat = 0;
        busy_ok = 1'b1;
        while (!done_o && lat < 200) begin
            if (!busy_o) busy_ok = 1'b0;
            start_i = (lat == inject_at);
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(busy_ok, "R3 busy high while running", {127'd0, busy_ok}, 128'd1);
        check(lat == 40, "R3 latency", 128'(lat), 128'd40);
        check(ct_o == exp, "R7 ciphertext", ct_o, exp);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_t[0] = 8'h01;
        for (int i = 1; i < 256; i++) exp_t[i] = exp_t[i-1] ^ xt(exp_t[i-1]);
        log_t[0] = 8'h00;
        for (int i = 0; i < 255; i++) log_t[exp_t[i]] = 8'(i);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && ct_o == '0, "R1 in reset", ct_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && ct_o == '0, "R1 after reset", ct_o, '0);

        // R2: known-answer vector and byte order
        run_vec(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, -1, 1'b0);
        check(ct_o == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 known answer",
              ct_o, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R4: done lasts one cycle, output held while idle and inputs move
        for (int k = 0; k < 5; k++) begin
            logic [127:0] held;
            held = ct_o;
            pt_i = {4{32'h5a5a0000 + 32'(k)}};
            key_i = ~pt_i;
            @(negedge clk);
            check(!done_o && !busy_o && ct_o == held, "R4 hold after done", ct_o, held);
        end

        // R7: corner vectors
        run_vec('0, '0, -1, 1'b0);
        check(ct_o == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R7 all-zero", ct_o,
              128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        run_vec('1, '1, -1, 1'b0);
        run_vec(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, -1, 1'b0);
        check(ct_o == 128'h3925841d02dc09fbdc118597196a0b32, "R7 second known answer", ct_o,
              128'h3925841d02dc09fbdc118597196a0b32);

        // R7 sweep of generated vectors, R5 stray start at every cycle offset
        for (int i = 0; i < 40; i++) begin
            logic [31:0] h;
            logic [127:0] p, k;
            h = 32'h9e3779b9 * 32'(i + 1);
            p = {h, h ^ 32'h7f4a7c15, h * 32'd3, ~h};
            k = {h * 32'd5, h ^ 32'hbb67ae85, h + 32'h3c6ef372, h * 32'd7};
            run_vec(p, k, i, 1'b0);
            @(negedge clk);
            check(!busy_o && !done_o, "R5 stray start ignored", {126'd0, busy_o, done_o}, '0);
        end

        // R6: back-to-back, start in the done cycle
        run_vec(128'h0123456789abcdeffedcba9876543210, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, -1, 1'b0);
        run_vec(128'hffeeddccbbaa99887766554433221100, 128'h00112233445566778899aabbccddeeff, -1, 1'b1);
        check(1'b1, "R6 chained start", '0, '0);
        @(negedge clk);
        check(!done_o, "R4 single-cycle done", {127'd0, done_o}, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule